// File: doc/BRIEF.md
# Per-Thread Outstanding Address Guard

This block sits in front of a data-memory port shared by several hardware threads. It keeps a small table of the addresses each thread currently has in flight. Each request presents a thread number, a sequence number and an address. The block answers grant or deny combinationally in the same cycle. A grant for a new address records that address together with the requester's sequence number. A later request from a different sequence number to the same address in the same thread is turned away until the first access retires. The owner itself may replay its access.

Entries leave the table when the memory side reports that an access has completed, or when the pipeline squashes younger work for a thread. A per-thread blocked flag is raised when address translation reports a fault. While it is set, every request from that thread is refused. It is cleared when a squash removes the faulting access. A build-time option turns the block into an instruction-fetch guard. In that variant the address comparison is skipped and only free table space decides the grant.

Top module: `otrk_top`

## Requirements
- R1: After a translation fault is reported for thread T (tfValid with tfTid=T), every request from T is denied starting the next cycle. Requests from other threads are unaffected.
- R2: A request whose address is not live in its thread's table is granted when that table has a free entry. On the clock edge the address and sequence number are stored. Each thread has its own table.
- R3: A request whose address is live in its thread's table is granted only if the stored sequence number equals reqSeq. A replay needs no free entry and adds no entry. Any other sequence number is denied.
- R4: With FETCH_PORT=1 the address check is skipped. Duplicate addresses are granted and stored, and a request is denied only when its thread's table has no free entry.
- R5: capErr[T] is 1 whenever thread T holds CAP_LIMIT entries, where CAP_LIMIT is the smaller of DEPTH and 10. Otherwise it is 0. A new address is denied while all DEPTH entries are occupied.
- R6: A completion (cmplValid, cmplTid, cmplAddr) removes one live entry of that thread holding cmplAddr. The address is then free for any sequence number.
- R7: A completion is applied before a request in the same cycle is evaluated. A request to the completing address is judged as if the entry were already gone, and it may reuse the freed entry.
- R8: A squash (sqValid, sqTid, sqSeq) removes the thread's entries whose sequence number is greater than sqSeq. With sqStall=1 the bound is sqSeq+1, so the stalled access keeps its entry. Sequence numbers compare as unsigned values.
- R9: A squash clears the thread's blocked flag when the faulting sequence number recorded with the fault is greater than the squash bound. Otherwise the flag stays set.
- R10: Reset (rstN low) empties every table, clears every blocked flag and drives capErr to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request present |
| reqTid | input | TW | Requesting thread |
| reqSeq | input | SEQ_W | Sequence number of the requester |
| reqAddr | input | ADDR_W | Requested address |
| reqGrant | output | 1 | Combinational grant for the current request |
| cmplValid | input | 1 | An access has completed |
| cmplTid | input | TW | Thread of the completed access |
| cmplAddr | input | ADDR_W | Address of the completed access |
| sqValid | input | 1 | Squash younger work of a thread |
| sqTid | input | TW | Thread being squashed |
| sqSeq | input | SEQ_W | Squash bound sequence number |
| sqStall | input | 1 | Squash caused by a memory stall (bound raised by one) |
| tfValid | input | 1 | Translation fault reported |
| tfTid | input | TW | Thread of the faulting access |
| tfSeq | input | SEQ_W | Sequence number of the faulting access |
| capErr | output | NUM_THREADS | Per-thread table-at-limit error flag |

## Verification
The bench targets the owner replay and the same-cycle completion-then-request case. A design that compared addresses alone would deny the replay. A design that evaluated the request before removal would refuse the reuse of a just-completed address. The stall squash is checked at its exact bound. An off-by-one there would drop the stalled access's entry, or keep a younger one that should be gone. The bench also exercises the blocked flag surviving a squash that does not reach the faulting access, and a full table where new addresses must be refused while replays still pass. A fetch-variant instance confirms that duplicates are accepted, which a design that left the comparison enabled would deny.

// File: rtl/otrk_pkg.sv
package otrk_pkg;

  // Strobes from the control to the address table
  typedef struct packed {
    logic alloc;   // store the current request in the first free entry
    logic squash;  // apply the squash bound to sqTid's entries
  } tblCmd_t;

  // Lookup results for the current request, after same-cycle removals
  typedef struct packed {
    logic hit;      // address live in the requesting thread's table
    logic ownHit;   // ... and held by the requesting sequence number
    logic hasFree;  // at least one entry free
  } lookRes_t;

endpackage

// File: rtl/otrk_table.sv
module otrk_table
  import otrk_pkg::*;
#(
  parameter int NT    = 2,
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int SW    = 16,
  parameter int TW    = 1,
  parameter bit FETCH = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] reqTid,
  input  logic [SW-1:0] reqSeq,
  input  logic [AW-1:0] reqAddr,
  input  logic          cmplValid,
  input  logic [TW-1:0] cmplTid,
  input  logic [AW-1:0] cmplAddr,
  input  logic [TW-1:0] sqTid,
  input  logic [SW-1:0] sqSeq,
  input  logic          sqStall,
  input  tblCmd_t       cmd,
  output lookRes_t      look,
  output logic [SW:0]   sqThr,
  output logic [NT-1:0] capErr
);

  localparam int IW        = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CAP_LIMIT = (DEPTH < 10) ? DEPTH : 10;

  logic [DEPTH-1:0] vldQ  [NT];
  logic [AW-1:0]    addrQ [NT][DEPTH];
  logic [SW-1:0]    seqQ  [NT][DEPTH];

  logic [DEPTH-1:0] cmplMask [NT];
  logic [DEPTH-1:0] sqMask   [NT];
  logic [DEPTH-1:0] live     [NT];

  logic [DEPTH-1:0] hitVec, ownVec, reqLive;
  logic [IW-1:0]    freeIdx;
  logic             freeFound;

  always_comb sqThr = {1'b0, sqSeq} + (SW+1)'(sqStall);

  // Removals that take effect this cycle (completion first-match, squash bound)
  always_comb begin
    for (int t = 0; t < NT; t++) begin
      logic found;
      found       = 1'b0;
      cmplMask[t] = '0;
      sqMask[t]   = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (cmplValid && cmplTid == TW'(t) && !found &&
            vldQ[t][i] && addrQ[t][i] == cmplAddr) begin
          cmplMask[t][i] = 1'b1;
          found          = 1'b1;
        end
        if (cmd.squash && sqTid == TW'(t) && vldQ[t][i] &&
            {1'b0, seqQ[t][i]} > sqThr)
          sqMask[t][i] = 1'b1;
      end
      live[t] = vldQ[t] & ~cmplMask[t] & ~sqMask[t];
    end
  end

  // Lookup for the requesting thread against the post-removal view
  always_comb begin
    reqLive = '0;
    hitVec  = '0;
    ownVec  = '0;
    for (int t = 0; t < NT; t++) begin
      if (reqTid == TW'(t)) begin
        reqLive = live[t];
        for (int i = 0; i < DEPTH; i++) begin
          if (live[t][i] && addrQ[t][i] == reqAddr) begin
            hitVec[i] = 1'b1;
            if (seqQ[t][i] == reqSeq) ownVec[i] = 1'b1;
          end
        end
      end
    end
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!freeFound && !reqLive[i]) begin
        freeIdx   = IW'(i);
        freeFound = 1'b1;
      end
    end
    look.hit     = |hitVec;
    look.ownHit  = |ownVec;
    look.hasFree = freeFound;
  end

  // Valid bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < NT; t++) vldQ[t] <= '0;
    end else begin
      for (int t = 0; t < NT; t++) begin
        vldQ[t] <= live[t];
        if (cmd.alloc && reqTid == TW'(t)) vldQ[t][freeIdx] <= 1'b1;
      end
    end
  end

  // Payload (no reset needed, qualified by valid bits)
  always_ff @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (cmd.alloc && reqTid == TW'(t)) begin
        addrQ[t][freeIdx] <= reqAddr;
        seqQ[t][freeIdx]  <= reqSeq;
      end
    end
  end

  // Error flag per thread
  generate
    for (genvar t = 0; t < NT; t++) begin : g_cap
      assign capErr[t] = ($countones(vldQ[t]) >= CAP_LIMIT);

      p_full_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
        (&vldQ[t]) |-> capErr[t])
        else $error("full table without capErr flag");
    end
  endgenerate

  p_alloc_has_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.alloc |-> look.hasFree)
    else $error("allocation without a free entry");

  generate
    if (!FETCH) begin : g_uniq
      logic dupFlag;
      always_comb begin
        dupFlag = 1'b0;
        for (int t = 0; t < NT; t++)
          for (int i = 0; i < DEPTH; i++)
            for (int j = i + 1; j < DEPTH; j++)
              if (vldQ[t][i] && vldQ[t][j] && addrQ[t][i] == addrQ[t][j])
                dupFlag = 1'b1;
      end

      p_unique_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
        !dupFlag)
        else $error("duplicate live address in one thread");
    end
  endgenerate

endmodule

// File: rtl/otrk_ctrl.sv
module otrk_ctrl
  import otrk_pkg::*;
#(
  parameter int NT    = 2,
  parameter int SW    = 16,
  parameter int TW    = 1,
  parameter bit FETCH = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [TW-1:0] reqTid,
  input  logic          sqValid,
  input  logic [TW-1:0] sqTid,
  input  logic [SW:0]   sqThr,
  input  logic          tfValid,
  input  logic [TW-1:0] tfTid,
  input  logic [SW-1:0] tfSeq,
  input  lookRes_t      look,
  output tblCmd_t       cmd,
  output logic          reqGrant
);

  logic [NT-1:0] blockQ;
  logic [SW-1:0] faultSeqQ [NT];
  logic          reqBlk;
  logic          addrOk;

  always_comb begin
    reqBlk = 1'b0;
    for (int t = 0; t < NT; t++)
      if (reqTid == TW'(t)) reqBlk = blockQ[t];

    if (FETCH) addrOk = look.hasFree;
    else       addrOk = look.hit ? look.ownHit : look.hasFree;

    reqGrant   = reqValid && !reqBlk && addrOk;
    cmd.alloc  = reqGrant && (FETCH || !look.hit);
    cmd.squash = sqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blockQ <= '0;
      for (int t = 0; t < NT; t++) faultSeqQ[t] <= '0;
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (tfValid && tfTid == TW'(t)) begin
          blockQ[t]    <= 1'b1;
          faultSeqQ[t] <= tfSeq;
        end else if (sqValid && sqTid == TW'(t) && blockQ[t] &&
                     {1'b0, faultSeqQ[t]} > sqThr) begin
          blockQ[t] <= 1'b0;
        end
      end
    end
  end

  p_blocked_deny_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (|(blockQ & (NT'(1) << reqTid)))) |-> !reqGrant)
    else $error("grant to a blocked thread");

  generate
    if (!FETCH) begin : g_replay
      p_replay_no_alloc_r3: assert property (@(posedge clk) disable iff (!rstN)
        look.ownHit |-> !cmd.alloc)
        else $error("replay created a second entry");
    end

    for (genvar t = 0; t < NT; t++) begin : g_unblk
      p_squash_unblock_r9: assert property (@(posedge clk) disable iff (!rstN)
        (sqValid && sqTid == TW'(t) && blockQ[t] &&
         {1'b0, faultSeqQ[t]} > sqThr && !(tfValid && tfTid == TW'(t)))
        |=> !blockQ[t])
        else $error("squash of faulting access left thread blocked");
    end
  endgenerate

endmodule

// File: rtl/otrk_top.sv
module otrk_top
  import otrk_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 8,
  parameter int ADDR_W      = 32,
  parameter int SEQ_W       = 16,
  parameter bit FETCH_PORT  = 1'b0,
  localparam int TW         = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [TW-1:0]          reqTid,
  input  logic [SEQ_W-1:0]       reqSeq,
  input  logic [ADDR_W-1:0]      reqAddr,
  output logic                   reqGrant,
  input  logic                   cmplValid,
  input  logic [TW-1:0]          cmplTid,
  input  logic [ADDR_W-1:0]      cmplAddr,
  input  logic                   sqValid,
  input  logic [TW-1:0]          sqTid,
  input  logic [SEQ_W-1:0]       sqSeq,
  input  logic                   sqStall,
  input  logic                   tfValid,
  input  logic [TW-1:0]          tfTid,
  input  logic [SEQ_W-1:0]       tfSeq,
  output logic [NUM_THREADS-1:0] capErr
);

  tblCmd_t       cmd;
  lookRes_t      look;
  logic [SEQ_W:0] sqThr;

  otrk_ctrl #(
    .NT(NUM_THREADS), .SW(SEQ_W), .TW(TW), .FETCH(FETCH_PORT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqTid(reqTid),
    .sqValid(sqValid), .sqTid(sqTid), .sqThr(sqThr),
    .tfValid(tfValid), .tfTid(tfTid), .tfSeq(tfSeq),
    .look(look), .cmd(cmd), .reqGrant(reqGrant)
  );

  otrk_table #(
    .NT(NUM_THREADS), .DEPTH(DEPTH), .AW(ADDR_W), .SW(SEQ_W), .TW(TW),
    .FETCH(FETCH_PORT)
  ) u_table (
    .clk(clk), .rstN(rstN),
    .reqTid(reqTid), .reqSeq(reqSeq), .reqAddr(reqAddr),
    .cmplValid(cmplValid), .cmplTid(cmplTid), .cmplAddr(cmplAddr),
    .sqTid(sqTid), .sqSeq(sqSeq), .sqStall(sqStall),
    .cmd(cmd), .look(look), .sqThr(sqThr), .capErr(capErr)
  );

endmodule

// File: tb/tb_otrk_top.sv
`timescale 1ns/100ps
module tb_otrk_top;

  typedef struct packed {
    logic        reqV;
    logic        tid;
    logic [7:0]  seq;
    logic [31:0] addr;
    logic        cmplV;
    logic [31:0] cmplAddr;
    logic        sqV;
    logic        sqStall;
    logic        tfV;
    logic        exp;
    logic [3:0]  rq;
  } stim_t;

  function automatic stim_t rq(input logic t, input logic [7:0] s,
                               input logic [31:0] a, input logic e,
                               input logic [3:0] r);
    stim_t v = '0;
    v.reqV = 1'b1; v.tid = t; v.seq = s; v.addr = a; v.exp = e; v.rq = r;
    return v;
  endfunction

  function automatic stim_t rc(input logic t, input logic [7:0] s,
                               input logic [31:0] a, input logic [31:0] c,
                               input logic e, input logic [3:0] r);
    stim_t v = rq(t, s, a, e, r);
    v.cmplV = 1'b1; v.cmplAddr = c;
    return v;
  endfunction

  function automatic stim_t cp(input logic t, input logic [31:0] c);
    stim_t v = '0;
    v.tid = t; v.cmplV = 1'b1; v.cmplAddr = c;
    return v;
  endfunction

  function automatic stim_t sq(input logic t, input logic [7:0] s,
                               input logic stall);
    stim_t v = '0;
    v.tid = t; v.sqV = 1'b1; v.seq = s; v.sqStall = stall;
    return v;
  endfunction

  function automatic stim_t tf(input logic t, input logic [7:0] s);
    stim_t v = '0;
    v.tid = t; v.tfV = 1'b1; v.seq = s;
    return v;
  endfunction

  localparam int NV = 9;
  localparam stim_t VEC [NV] = '{
    rq(1'b0, 8'd5,  32'h100, 1'b1, 4'd2),           // R2 new address
    rq(1'b0, 8'd6,  32'h100, 1'b0, 4'd3),           // R3 other seq denied
    rq(1'b0, 8'd5,  32'h100, 1'b1, 4'd3),           // R3 owner replay
    rq(1'b1, 8'd6,  32'h100, 1'b1, 4'd2),           // R2 separate thread
    rq(1'b0, 8'd7,  32'h200, 1'b1, 4'd2),
    rc(1'b0, 8'd8,  32'h100, 32'h100, 1'b1, 4'd7),  // R7 same cycle
    rq(1'b0, 8'd9,  32'h100, 1'b0, 4'd3),           // R3 new owner is seq 8
    cp(1'b0, 32'h200),                              // R6 completion alone
    rq(1'b0, 8'd10, 32'h200, 1'b1, 4'd6)            // R6 freed address
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid, reqTid, cmplValid, cmplTid, sqValid, sqTid, sqStall;
  logic        tfValid, tfTid;
  logic [15:0] reqSeq, sqSeq, tfSeq;
  logic [31:0] reqAddr, cmplAddr;
  logic        reqGrant, fGrant;
  logic [1:0]  capErr, fCap;

  int nChk  = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  otrk_top dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqTid(reqTid), .reqSeq(reqSeq), .reqAddr(reqAddr),
    .reqGrant(reqGrant),
    .cmplValid(cmplValid), .cmplTid(cmplTid), .cmplAddr(cmplAddr),
    .sqValid(sqValid), .sqTid(sqTid), .sqSeq(sqSeq), .sqStall(sqStall),
    .tfValid(tfValid), .tfTid(tfTid), .tfSeq(tfSeq),
    .capErr(capErr)
  );

  otrk_top #(.FETCH_PORT(1'b1)) dutFetch (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqTid(reqTid), .reqSeq(reqSeq), .reqAddr(reqAddr),
    .reqGrant(fGrant),
    .cmplValid(cmplValid), .cmplTid(cmplTid), .cmplAddr(cmplAddr),
    .sqValid(sqValid), .sqTid(sqTid), .sqSeq(sqSeq), .sqStall(sqStall),
    .tfValid(tfValid), .tfTid(tfTid), .tfSeq(tfSeq),
    .capErr(fCap)
  );

  task automatic drive(input stim_t s);
    reqValid  = s.reqV;  reqTid  = s.tid; reqSeq = 16'(s.seq); reqAddr = s.addr;
    cmplValid = s.cmplV; cmplTid = s.tid; cmplAddr = s.cmplAddr;
    sqValid   = s.sqV;   sqTid   = s.tid; sqSeq  = 16'(s.seq); sqStall = s.sqStall;
    tfValid   = s.tfV;   tfTid   = s.tid; tfSeq  = 16'(s.seq);
  endtask

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; grant is combinational so sample before the edge
  task automatic cyc(input stim_t s, input string tag, input bit useF);
    @(negedge clk);
    drive(s);
    #1;
    if (s.reqV) chk(tag, {31'd0, useF ? fGrant : reqGrant}, {31'd0, s.exp});
    @(posedge clk);
    #0.5;
    drive('0);
  endtask

  task automatic capChk(input string tag, input logic [1:0] exp);
    @(negedge clk);
    #1;
    chk(tag, {30'd0, capErr}, {30'd0, exp});
  endtask

  task automatic doReset();
    @(negedge clk);
    drive('0);
    rstN = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(4.0 * 200000);
    nFail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    drive('0);
    doReset();

    // R10: reset state
    capChk("R10 capErr after reset", 2'b00);
    cyc(rq(1'b0, 8'd1, 32'habc, 1'b1, 4'd10), "R10 first grant", 1'b0);
    doReset();

    // vector walk
    for (int k = 0; k < NV; k++)
      cyc(VEC[k], $sformatf("R%0d vector %0d", VEC[k].rq, k), 1'b0);

    // R10: reset mid-run drops all entries (0x100 was owned by seq 8)
    doReset();
    cyc(rq(1'b0, 8'd9, 32'h100, 1'b1, 4'd10), "R10 table cleared", 1'b0);

    // R8: plain squash, bound 4
    doReset();
    cyc(rq(1'b0, 8'd3, 32'h10, 1'b1, 4'd8), "R8 setup", 1'b0);
    cyc(rq(1'b0, 8'd5, 32'h20, 1'b1, 4'd8), "R8 setup", 1'b0);
    cyc(rq(1'b0, 8'd7, 32'h30, 1'b1, 4'd8), "R8 setup", 1'b0);
    cyc(sq(1'b0, 8'd4, 1'b0), "R8 squash", 1'b0);
    cyc(rq(1'b0, 8'd9,  32'h20, 1'b1, 4'd8), "R8 younger removed", 1'b0);
    cyc(rq(1'b0, 8'd11, 32'h10, 1'b0, 4'd8), "R8 older kept", 1'b0);

    // R8: stall squash, bound 3+1 keeps seq 4
    doReset();
    cyc(rq(1'b0, 8'd3, 32'h10, 1'b1, 4'd8), "R8 setup", 1'b0);
    cyc(rq(1'b0, 8'd4, 32'h20, 1'b1, 4'd8), "R8 setup", 1'b0);
    cyc(rq(1'b0, 8'd5, 32'h30, 1'b1, 4'd8), "R8 setup", 1'b0);
    cyc(sq(1'b0, 8'd3, 1'b1), "R8 stall squash", 1'b0);
    cyc(rq(1'b0, 8'd9, 32'h20, 1'b0, 4'd8), "R8 stalled access kept", 1'b0);
    cyc(rq(1'b0, 8'd9, 32'h30, 1'b1, 4'd8), "R8 seq above bound removed", 1'b0);

    // R1 / R9: translation block
    doReset();
    cyc(tf(1'b0, 8'd6), "R1 fault", 1'b0);
    cyc(rq(1'b0, 8'd1, 32'h40, 1'b0, 4'd1), "R1 blocked thread denied", 1'b0);
    cyc(rq(1'b1, 8'd1, 32'h40, 1'b1, 4'd1), "R1 other thread granted", 1'b0);
    cyc(sq(1'b0, 8'd7, 1'b0), "R9 squash above fault", 1'b0);
    cyc(rq(1'b0, 8'd1, 32'h40, 1'b0, 4'd9), "R9 still blocked", 1'b0);
    cyc(sq(1'b0, 8'd5, 1'b0), "R9 squash covers fault", 1'b0);
    cyc(rq(1'b0, 8'd1, 32'h40, 1'b1, 4'd9), "R9 unblocked", 1'b0);

    // R5: fill thread 0
    doReset();
    for (int i = 0; i < 8; i++)
      cyc(rq(1'b0, 8'(i + 1), 32'h1000 + 32'(i * 4), 1'b1, 4'd5),
          "R5 fill", 1'b0);
    capChk("R5 capErr at limit", 2'b01);
    cyc(rq(1'b0, 8'd20, 32'h2000, 1'b0, 4'd5), "R5 full denies new", 1'b0);
    cyc(rq(1'b0, 8'd3,  32'h1008, 1'b1, 4'd3), "R3 replay when full", 1'b0);
    cyc(rc(1'b0, 8'd21, 32'h2000, 32'h1000, 1'b1, 4'd7),
        "R7 freed entry reused", 1'b0);
    capChk("R5 still at limit", 2'b01);
    cyc(cp(1'b0, 32'h1004), "R6 completion", 1'b0);
    capChk("R5 below limit", 2'b00);

    // R4: fetch variant accepts duplicates, limited by space only
    doReset();
    cyc(rq(1'b0, 8'd1, 32'h50, 1'b1, 4'd4), "R4 fetch first", 1'b1);
    cyc(rq(1'b0, 8'd2, 32'h50, 1'b1, 4'd4), "R4 fetch duplicate", 1'b1);
    for (int i = 0; i < 6; i++)
      cyc(rq(1'b0, 8'(i + 3), 32'h50, 1'b1, 4'd4), "R4 fetch fill", 1'b1);
    cyc(rq(1'b0, 8'd30, 32'h60, 1'b0, 4'd4), "R4 fetch full", 1'b1);

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule